// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous request port reach an external asynchronous byte-wide static memory of one million locations. A client presents an address, a direction bit and write data under a valid/ready handshake. The controller then runs one complete memory cycle on the external pins: a select, a write-enable pulse or an output-enable window, and a data bus driven only while writing. A read returns its byte with a single-cycle response pulse.

The memory is selected by a pair of chip enables of opposite polarity: the active-low enable must be low and the active-high enable must be high. Whenever no access is in flight, both enables are parked in the deselected state so the memory can fall into standby. The length of the strobe window is derived from two parameters, the clock period and the slowest access-time grade to be supported. Every access is framed by one setup clock before the strobe and one hold clock after it, with address and select held steady across the whole frame.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it, the memory is deselected (active-low enable 1, active-high enable 0), write enable and output enable are high, the data bus is not driven, reqReady is 1 and rspValid is 0.
- R2: Whenever reqReady is 1 the memory is deselected, and it is selected only while an accepted access is in progress.
- R3: Write enable is low only while the memory is selected, output enable is high and the controller drives the data bus with the accepted write byte.
- R4: In the clock before write enable falls and the clock after it rises, the memory is selected with the same address and write enable high.
- R5: A read holds output enable low, with write enable high and the memory selected, for exactly WAIT_CYC clocks, and a write holds write enable low for exactly WAIT_CYC clocks.
- R6: The controller never drives the data bus while output enable is low.
- R7: Each read gives exactly one single-cycle rspValid pulse carrying the byte stored at its address; a write gives none.
- R8: A request is accepted on a clock where reqValid and reqReady are both 1; reqReady is 1 only when idle and stays 0 for WAIT_CYC+2 clocks after acceptance, with the read response in the last of them.
- R9: WAIT_CYC equals the access time divided by the clock period, rounded up (70 ns at 8 ns gives 9), and at least 1.
- R10: The memory address equals the accepted address and stays constant while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request may be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Memory location |
| reqWdata | input | 8 | Byte to write |
| rspValid | output | 1 | One-clock pulse with read data |
| rspData | output | 8 | Read byte |
| memAddr | output | 20 | Address pins |
| memCe1N | output | 1 | Chip enable, active low |
| memCe2 | output | 1 | Chip enable, active high |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqOe | output | 1 | 1 = controller drives the data bus |
| memDqIn | input | 8 | Data read from the bus |

## Verification
The assertions assume that the request fields stay stable from the cycle a request is offered until it is accepted, and that the external memory returns valid data no later than the configured access time after output enable falls. The bench changes request fields only while reqValid is low or in the accept cycle, and its memory model returns a poison byte until exactly 70 ns after each read select settles, so a window shorter than the grade shows up as wrong read data. The model also watches the pins each cycle for bus contention, writes outside a select, and address or select changes around the write pulse.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } ctlState_e;

  typedef struct packed {
    logic latchReq;
    logic selMem;
    logic weAct;
    logic oeAct;
    logic driveDq;
    logic capture;
  } ctlStrb_t;
endpackage

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
  import asram_pkg::*;
#(
  parameter int WAIT_CYC = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output ctlStrb_t strb
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

  ctlState_e  state, stateNxt;
  logic [CNT_W-1:0] waitCnt;
  logic       isWrite;
  logic       accept;
  logic       waitDone;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign waitDone = (waitCnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNxt = ST_SETUP;
      ST_SETUP:  stateNxt = ST_ACCESS;
      ST_ACCESS: if (waitDone) stateNxt = ST_HOLD;
      ST_HOLD:   stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) isWrite <= reqWrite;
      if (state == ST_SETUP) waitCnt <= CNT_W'(WAIT_CYC - 1);
      else if (state == ST_ACCESS && !waitDone) waitCnt <= waitCnt - 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.latchReq = accept;
    strb.selMem   = (state != ST_IDLE);
    strb.weAct    = (state == ST_ACCESS) && isWrite;
    strb.oeAct    = (state == ST_ACCESS) && !isWrite;
    strb.driveDq  = (state != ST_IDLE) && isWrite;
    strb.capture  = (state == ST_ACCESS) && !isWrite && waitDone;
  end
endmodule

// File: rtl/asram_dp.sv
`timescale 1ns/1ps
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= memDqIn;
      rspQ <= strb.capture;
    end
  end

  assign memAddr  = addrQ;
  assign memCe1N  = ~strb.selMem;
  assign memCe2   = strb.selMem;
  assign memWeN   = ~strb.weAct;
  assign memOeN   = ~strb.oeAct;
  assign memDqOut = wdataQ;
  assign memDqOe  = strb.driveDq;
  assign rspValid = rspQ;
  assign rspData  = rdataQ;
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int ACCESS_PS     = 70000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);
  localparam int WAIT_RAW = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  ctlStrb_t strb;

  asram_ctl #(.WAIT_CYC(WAIT_CYC)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strb     (strb)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memAddr  (memAddr),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );
endmodule

// File: rtl/asram_chk.sv
`timescale 1ns/1ps
module asram_chk #(
  parameter int ADDR_W   = 20,
  parameter int WAIT_CYC = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe
);
  localparam int LEN_W = $clog2(WAIT_CYC + 2) + 1;

  logic [LEN_W-1:0] oeLen;
  logic [LEN_W-1:0] weLen;
  logic             sel;

  assign sel = !memCe1N && memCe2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeLen <= '0;
      weLen <= '0;
    end else begin
      oeLen <= memOeN ? '0 : ((&oeLen) ? oeLen : oeLen + 1'b1);
      weLen <= memWeN ? '0 : ((&weLen) ? weLen : weLen + 1'b1);
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2)); // R2
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memWeN && memOeN && !memDqOe)); // R8
  AST_WE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (sel && memDqOe && memOeN)); // R3
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(sel) && $stable(memAddr))); // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (sel && $stable(memAddr))); // R4
  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLen == LEN_W'(WAIT_CYC))); // R5
  AST_WE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLen == LEN_W'(WAIT_CYC))); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOe && !memOeN)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (sel && $past(sel)) |-> $stable(memAddr)); // R10
endmodule

bind asram_ctrl asram_chk #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memAddr  (memAddr),
  .memCe1N  (memCe1N),
  .memCe2   (memCe2),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memDqOe  (memDqOe)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;
  localparam int CLK_NS    = 8;
  localparam int ACCESS_NS = 70;
  localparam int N_WR      = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [19:0] memAddr;
  logic        memCe1N, memCe2, memWeN, memOeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  dqDrive = 8'hEE;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_PS(CLK_NS*1000), .ACCESS_PS(ACCESS_NS*1000)) i_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(dqDrive)
  );

  // R9: expected window length from the grade and the clock period
  function automatic int expWait();
    int w = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int expBusy();
    return expWait() + 2;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory
  logic [7:0] modelMem [int unsigned];
  logic [7:0] expMem   [int unsigned];
  int unsigned rdGen = 0;

  function automatic logic [7:0] modelRd(input logic [19:0] a);
    return modelMem.exists(a) ? modelMem[a] : 8'h00;
  endfunction

  task automatic launchValid(input int unsigned g);
    fork
      begin
        #(ACCESS_NS);
        if (g == rdGen) dqDrive = modelRd(memAddr);
      end
    join_none
  endtask

  always @(memOeN or memCe1N or memCe2 or memWeN or memAddr) begin
    rdGen = rdGen + 1;
    dqDrive = 8'hEE;
    if (!memCe1N && memCe2 && memWeN && !memOeN) launchValid(rdGen);
  end

  // pin-rule monitor
  int vContention = 0, vWeRule = 0, vStandby = 0, vFrame = 0;
  logic        prevWeN = 1'b1, prevSel = 1'b0;
  logic [19:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic sel = !memCe1N && memCe2;
      if (memDqOe && !memOeN) begin
        vContention++; $display("FAIL R6 actual=%0h expected=%0h", {memDqOe, memOeN}, 2'b10);
      end
      if (!memWeN && !(sel && memDqOe && memOeN)) begin
        vWeRule++; $display("FAIL R3 actual=%0h expected=%0h", {sel, memDqOe, memOeN}, 3'b111);
      end
      if (reqReady && !(memCe1N && !memCe2)) begin
        vStandby++; $display("FAIL R2 actual=%0h expected=%0h", {memCe1N, memCe2}, 2'b10);
      end
      if (prevWeN && !memWeN && !(prevSel && prevAddr == memAddr)) begin
        vFrame++; $display("FAIL R4 actual=%0h expected=%0h", memAddr, prevAddr);
      end
      if (!prevWeN && memWeN && !(sel && prevAddr == memAddr)) begin
        vFrame++; $display("FAIL R4 actual=%0h expected=%0h", memAddr, prevAddr);
      end
      if (!memWeN && sel) modelMem[memAddr] = memDqOut;
      prevWeN  = memWeN;
      prevSel  = sel;
      prevAddr = memAddr;
    end
  end

  task automatic doAccess(input bit wr, input logic [19:0] a, input logic [7:0] d,
                          output int busy, output int rspCnt, output int rspAt,
                          output logic [7:0] rd);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    busy = 0; rspCnt = 0; rspAt = 0; rd = 8'h00;
    while (!reqReady && busy < 1000) begin
      busy++;
      if (rspValid) begin rspCnt++; rspAt = busy; rd = rspData; end
      @(negedge clk);
    end
    if (wr) expMem[a] = d;
  endtask

  task automatic wrCheck(input logic [19:0] a, input logic [7:0] d);
    int busy, rc, ra; logic [7:0] rd;
    doAccess(1'b1, a, d, busy, rc, ra, rd);
    check(busy == expBusy(), "R8", busy, expBusy());
    check(rc == 0, "R7", rc, 0);
  endtask

  task automatic rdCheck(input logic [19:0] a);
    int busy, rc, ra; logic [7:0] rd;
    logic [7:0] e = expMem.exists(a) ? expMem[a] : 8'h00;
    doAccess(1'b0, a, 8'h00, busy, rc, ra, rd);
    check(rc == 1, "R7", rc, 1);
    check(rd == e, "R5/R7 read data", rd, e);
    check(ra == expBusy(), "R8 response slot", ra, expBusy());
    check(busy == expBusy(), "R8", busy, expBusy());
  endtask

  bit done = 1'b0;

  initial begin
    logic [19:0] addrs [N_WR];
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memCe1N == 1'b1 && memCe2 == 1'b0, "R1 select", {memCe1N, memCe2}, 2'b10);
    check(memWeN && memOeN, "R1 strobes", {memWeN, memOeN}, 2'b11);
    check(!memDqOe && reqReady && !rspValid, "R1 bus/handshake",
          {memDqOe, reqReady, rspValid}, 3'b010);
    rstN = 1'b1;
    @(negedge clk);
    check(memCe1N && !memCe2 && reqReady, "R1 after reset", {memCe1N, memCe2, reqReady}, 3'b101);
    check(expWait() == 9, "R9", expWait(), 9);

    // directed corners: lowest and highest address, back-to-back write/read
    wrCheck(20'h00000, 8'h3C);
    wrCheck(20'hFFFFF, 8'hC3);
    rdCheck(20'h00000);
    rdCheck(20'hFFFFF);
    wrCheck(20'h55555, 8'hFF);
    rdCheck(20'h55555);
    wrCheck(20'h55555, 8'h00);
    rdCheck(20'h55555);

    // random writes then read-back (R10: address routing)
    for (int i = 0; i < N_WR; i++) begin
      addrs[i] = 20'($urandom());
      wrCheck(addrs[i], 8'($urandom()));
    end
    for (int i = N_WR - 1; i >= 0; i--) rdCheck(addrs[i]);

    // R10: reqAddr changed while busy must not disturb the access
    begin
      int busy, rc, ra; logic [7:0] rd;
      fork
        doAccess(1'b0, 20'hFFFFF, 8'h00, busy, rc, ra, rd);
        begin repeat (3) @(negedge clk); reqAddr = 20'h00000; end
      join
      check(rd == expMem[20'hFFFFF], "R10 address held", rd, expMem[20'hFFFFF]);
    end

    repeat (3) @(negedge clk);
    check(memCe1N && !memCe2, "R2 standby", {memCe1N, memCe2}, 2'b10);
    check(vContention == 0, "R6", vContention, 0);
    check(vWeRule == 0, "R3", vWeRule, 0);
    check(vStandby == 0, "R2", vStandby, 0);
    check(vFrame == 0, "R4", vFrame, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule